// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block keeps a small file of 128-bit vector registers and applies one packed integer operation per cycle to two of them, writing the result back into a third. Each operation views its registers as a row of independent lanes. The lane width is chosen per operation, and the four functions are wrapping add, wrapping subtract, maximum and minimum. Maximum and minimum compare either as signed or as unsigned numbers.

A host fills registers through a load port and observes them through a registered read port. It then issues operations by naming an opcode, a lane-width code, a signed flag, two source indices and a destination index. One adder chain, cut into bytes, serves every lane width. Its carries are killed at lane boundaries at run time.

Top module: `vec_lane_alu`

## Requirements
- R1: The register file holds eight registers of 128 bits. A load with `ld_en` high writes `ld_data` into register `ld_idx` at the next rising edge. `rd_data` is registered: it shows register `rd_idx` one edge after `rd_idx` is sampled. `rd_data` is 0 during and after reset until the first read.
- R2: Opcode 0 (add) sums corresponding lanes modulo 2^lane-width, and no carry crosses a lane boundary. The lane codes are 0 = sixteen 8-bit lanes, 1 = eight 16-bit lanes, 2 = four 32-bit lanes, 3 = two 64-bit lanes, 4 = one 128-bit lane.
- R3: Opcode 1 (subtract) computes source A minus source B per lane modulo 2^lane-width, and no borrow crosses a lane boundary.
- R4: Opcode 2 (max) and opcode 3 (min) pick the larger or smaller lane value. With `op_signed` low the lanes compare as unsigned numbers.
- R5: With `op_signed` high, max and min compare lanes as two's-complement signed numbers.
- R6: Lane k of the result depends only on lane k of the two sources, and lane 0 occupies the least significant bits.
- R7: A valid operation writes its destination at the rising edge that ends its cycle. A read of that register sampled at the same edge returns the old value. An operation in the next cycle may use the new value as a source.
- R8: An operation with an undefined opcode (4 to 7) or an undefined lane code (5 to 7) writes nothing.
- R9: When a legal operation and a load occur in the same cycle, the operation result is written and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request this cycle |
| op_code | input | 3 | 0 add, 1 sub, 2 max, 3 min |
| op_lane | input | 3 | Lane width code, 0..4 |
| op_signed | input | 1 | Signed compare for max/min |
| op_src_a | input | 3 | Index of source A |
| op_src_b | input | 3 | Index of source B |
| op_dst | input | 3 | Index of destination |
| ld_en | input | 1 | Load request |
| ld_idx | input | 3 | Register to load |
| ld_data | input | 128 | Load data |
| rd_idx | input | 3 | Register to read |
| rd_data | output | 128 | Registered read data |

## Verification
Some patterns place an all-ones or all-zero value in the bottom lane and a 1 in the other source. The result then shows whether a carry or borrow leaked into the next lane at each width, or whether the single 128-bit lane wraps correctly. Other patterns pair 0x80 with 0x7F, or a large negative 64-bit value with 1. Under both signed settings these separate signed from unsigned comparison. Multi-lane patterns put different winners in different lanes to expose any lane mix-up. Directed cases cover the read port at the write edge, an operation chained on the previous result, undefined codes, and a load that collides with an operation.

// File: rtl/valu_pkg.sv
package valu_pkg;
  localparam int OPW   = 3;
  localparam int LSELW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MAX = 3'd2,
    OP_MIN = 3'd3
  } vop_e;

  localparam logic [LSELW-1:0] LANE_CODES = 3'd5;
endpackage

// File: rtl/vec_regfile.sv
module vec_regfile #(
  parameter int W     = 128,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] sa,
  input  logic [AW-1:0] sb,
  output logic [W-1:0]  da,
  output logic [W-1:0]  db,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign da = mem[sa];
  assign db = mem[sb];

  always_ff @(posedge clk) begin
    if (rst) rd <= '0;
    else     rd <= mem[ra];
  end

  logic [W-1:0] cur_at_ra;
  assign cur_at_ra = mem[ra];

  // R7: read sampled at a write edge to the same index shows the old contents
  a_r7_read_old: assert property (@(posedge clk) disable iff (rst)
    (we && wa == ra) |=> rd == $past(cur_at_ra));

  // R1: read data is zero while reset is applied
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (rd == '0) || !$past(rst));
endmodule

// File: rtl/lane_addsub.sv
module lane_addsub #(
  parameter int VEC_W  = 128,
  parameter int BYTE_W = 8,
  localparam int NB    = VEC_W / BYTE_W
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic             sub,
  input  logic [2:0]       lane,
  output logic [VEC_W-1:0] y
);
  logic [VEC_W-1:0] bx;
  assign bx = sub ? ~b : b;

  always_comb begin
    logic          c;
    logic [BYTE_W:0] t;
    int lmask;
    lmask = (1 << lane) - 1;
    c = sub;
    y = '0;
    for (int i = 0; i < NB; i++) begin
      if ((i & lmask) == 0) c = sub;
      t = {1'b0, a[i*BYTE_W +: BYTE_W]} + {1'b0, bx[i*BYTE_W +: BYTE_W]}
          + {{BYTE_W{1'b0}}, c};
      y[i*BYTE_W +: BYTE_W] = t[BYTE_W-1:0];
      c = t[BYTE_W];
    end
  end
endmodule

// File: rtl/lane_minmax.sv
module lane_minmax #(
  parameter int VEC_W  = 128,
  parameter int BYTE_W = 8,
  localparam int NB    = VEC_W / BYTE_W,
  localparam int NLW   = $clog2(NB) + 1
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic             want_max,
  input  logic             sgn,
  input  logic [2:0]       lane,
  output logic [VEC_W-1:0] y
);
  logic [VEC_W-1:0] by_w [NLW];

  for (genvar k = 0; k < NLW; k++) begin : g_w
    localparam int LW = BYTE_W << k;
    localparam int NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_l
      logic [LW-1:0] la, lb;
      logic          a_lt;
      assign la = a[l*LW +: LW];
      assign lb = b[l*LW +: LW];
      assign a_lt = sgn ? ($signed(la) < $signed(lb)) : (la < lb);
      assign by_w[k][l*LW +: LW] = (a_lt == want_max) ? lb : la;
    end
  end

  always_comb begin
    y = by_w[0];
    for (int k = 0; k < NLW; k++) begin
      if (int'(lane) == k) y = by_w[k];
    end
  end
endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
  import valu_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int BYTE_W = 8,
  parameter int NREG   = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [2:0]       op_lane,
  input  logic             op_signed,
  input  logic [AW-1:0]    op_src_a,
  input  logic [AW-1:0]    op_src_b,
  input  logic [AW-1:0]    op_dst,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_idx,
  input  logic [VEC_W-1:0] ld_data,
  input  logic [AW-1:0]    rd_idx,
  output logic [VEC_W-1:0] rd_data
);
  logic [VEC_W-1:0] src_a, src_b, sum_y, mm_y, alu_res, rf_wd;
  logic [AW-1:0]    rf_wa;
  logic             op_legal, op_fire, rf_we, is_arith;

  assign op_legal = (op_code <= 3'(OP_MIN)) && (op_lane < LANE_CODES);
  assign op_fire  = op_valid && op_legal;
  assign is_arith = (op_code == 3'(OP_ADD)) || (op_code == 3'(OP_SUB));

  lane_addsub #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) u_add (
    .a(src_a), .b(src_b), .sub(op_code == 3'(OP_SUB)), .lane(op_lane), .y(sum_y)
  );

  lane_minmax #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) u_mm (
    .a(src_a), .b(src_b), .want_max(op_code == 3'(OP_MAX)), .sgn(op_signed),
    .lane(op_lane), .y(mm_y)
  );

  assign alu_res = is_arith ? sum_y : mm_y;

  // operation has priority over the load port
  assign rf_we = op_fire || ld_en;
  assign rf_wa = op_fire ? op_dst : ld_idx;
  assign rf_wd = op_fire ? alu_res : ld_data;

  vec_regfile #(.W(VEC_W), .DEPTH(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .sa(op_src_a), .sb(op_src_b), .da(src_a), .db(src_b),
    .ra(rd_idx), .rd(rd_data)
  );

  a_r2_add_identity: assert property (@(posedge clk) disable iff (rst)
    (op_fire && op_code == 3'(OP_ADD) && src_b == '0) |-> sum_y == src_a);

  a_r3_sub_self_zero: assert property (@(posedge clk) disable iff (rst)
    (op_fire && op_code == 3'(OP_SUB) && src_a == src_b) |-> sum_y == '0);

  a_r4_minmax_pick: assert property (@(posedge clk) disable iff (rst)
    (op_fire && !is_arith && op_lane == 3'd4) |-> (mm_y == src_a || mm_y == src_b));

  a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_legal && !ld_en) |-> !rf_we);

  a_r9_op_wins: assert property (@(posedge clk) disable iff (rst)
    (op_fire && ld_en) |-> (rf_wa == op_dst && rf_wd == alu_res));
endmodule

// File: tb/tb_vec_lane_alu.sv
module tb_vec_lane_alu;
  logic clk = 0;
  logic rst;
  logic op_valid, op_signed, ld_en;
  logic [2:0] op_code, op_lane, op_src_a, op_src_b, op_dst, ld_idx, rd_idx;
  logic [127:0] ld_data, rd_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  vec_lane_alu dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_lane(op_lane),
    .op_signed(op_signed), .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // {op, lane, signed, a, b, expected}
  localparam int NV = 16;
  localparam logic [3+3+1+384-1:0] VEC [NV] = '{
    {3'd0, 3'd0, 1'b0, 128'h00FF, 128'h0001, 128'h0000},
    {3'd0, 3'd1, 1'b0, 128'h00FF, 128'h0001, 128'h0100},
    {3'd0, 3'd4, 1'b0, {128{1'b1}}, 128'h1, 128'h0},
    {3'd0, 3'd3, 1'b0, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 128'h1, 128'h0},
    {3'd0, 3'd2, 1'b0, 128'h0000_0001_FFFF_FFFF, 128'h1, 128'h0000_0001_0000_0000},
    {3'd1, 3'd0, 1'b0, 128'h0, 128'h1, 128'hFF},
    {3'd1, 3'd1, 1'b0, 128'h0, 128'h1, 128'hFFFF},
    {3'd1, 3'd4, 1'b0, 128'h0, 128'h1, {128{1'b1}}},
    {3'd2, 3'd0, 1'b0, 128'h80, 128'h7F, 128'h80},
    {3'd2, 3'd0, 1'b1, 128'h80, 128'h7F, 128'h7F},
    {3'd3, 3'd0, 1'b0, 128'h80, 128'h7F, 128'h7F},
    {3'd3, 3'd0, 1'b1, 128'h80, 128'h7F, 128'h80},
    {3'd2, 3'd1, 1'b1, 128'h0001_FFFF, 128'h0002_0000, 128'h0002_0000},
    {3'd3, 3'd2, 1'b0, 128'h0000_0005_0000_0009, 128'h0000_0007_0000_0003,
                       128'h0000_0005_0000_0003},
    {3'd2, 3'd3, 1'b1, {64'h8000_0000_0000_0000, 64'h1}, {64'h1, 64'h8000_0000_0000_0000},
                       {64'h1, 64'h1}},
    {3'd1, 3'd4, 1'b1, 128'h5, 128'h3, 128'h2}
  };
  localparam string VTAG [NV] = '{"R2","R2","R2","R2","R6","R3","R3","R3",
                                  "R4","R5","R4","R5","R6","R6","R5","R3"};

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [127:0] d);
    @(negedge clk); ld_en = 1; ld_idx = idx; ld_data = d;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic read(input logic [2:0] idx, output logic [127:0] d);
    @(negedge clk); rd_idx = idx;
    @(negedge clk); d = rd_data;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [2:0] ln, input logic sg,
                        input logic [2:0] a, input logic [2:0] b, input logic [2:0] d);
    @(negedge clk);
    op_valid = 1; op_code = op; op_lane = ln; op_signed = sg;
    op_src_a = a; op_src_b = b; op_dst = d;
    @(negedge clk); op_valid = 0;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] got;
    rst = 1; op_valid = 0; op_code = 0; op_lane = 0; op_signed = 0;
    op_src_a = 0; op_src_b = 0; op_dst = 0; ld_en = 0; ld_idx = 0; ld_data = 0; rd_idx = 0;
    repeat (4) @(negedge clk);
    check("R1 reset", rd_data, 128'h0);
    rst = 0;

    load(3'd4, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_0011_2233);
    read(3'd4, got);
    check("R1 load/read", got, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_0011_2233);

    for (int i = 0; i < NV; i++) begin
      load(3'd1, VEC[i][383:256]);
      load(3'd2, VEC[i][255:128]);
      run_op(VEC[i][390:388], VEC[i][387:385], VEC[i][384], 3'd1, 3'd2, 3'd3);
      read(3'd3, got);
      check(VTAG[i], got, VEC[i][127:0]);
    end

    // R7: read at the write edge returns old value, then new
    load(3'd5, 128'h1111);
    load(3'd1, 128'h0202);
    load(3'd2, 128'h0303);
    @(negedge clk);
    op_valid = 1; op_code = 3'd0; op_lane = 3'd0; op_signed = 0;
    op_src_a = 3'd1; op_src_b = 3'd2; op_dst = 3'd5; rd_idx = 3'd5;
    @(negedge clk); op_valid = 0;
    check("R7 read-old", rd_data, 128'h1111);
    read(3'd5, got);
    check("R7 new value", got, 128'h0505);
    // R7: chain on previous result in the next cycle
    @(negedge clk);
    op_valid = 1; op_code = 3'd0; op_lane = 3'd0; op_src_a = 3'd5; op_src_b = 3'd5; op_dst = 3'd6;
    @(negedge clk);
    op_code = 3'd0; op_src_a = 3'd6; op_src_b = 3'd5; op_dst = 3'd6;
    @(negedge clk); op_valid = 0;
    read(3'd6, got);
    check("R7 chained", got, 128'h0F0F);

    // R8: undefined opcode and undefined lane code write nothing
    load(3'd7, 128'hCAFE);
    run_op(3'd5, 3'd0, 1'b0, 3'd1, 3'd2, 3'd7);
    read(3'd7, got);
    check("R8 bad opcode", got, 128'hCAFE);
    run_op(3'd0, 3'd6, 1'b0, 3'd1, 3'd2, 3'd7);
    read(3'd7, got);
    check("R8 bad lane", got, 128'hCAFE);

    // R9: op and load to same register in one cycle, op wins
    @(negedge clk);
    op_valid = 1; op_code = 3'd1; op_lane = 3'd1; op_signed = 0;
    op_src_a = 3'd2; op_src_b = 3'd1; op_dst = 3'd0;
    ld_en = 1; ld_idx = 3'd0; ld_data = 128'hBAD;
    @(negedge clk); op_valid = 0; ld_en = 0;
    read(3'd0, got);
    check("R9 op over load", got, 128'h0101);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule